// File: doc/BRIEF.md
# Fractional-Ratio Clock Enable Generator

This block turns a fast reference clock into a stream of single-cycle enable pulses. On average it produces 18 pulses for every N reference cycles, where N is a 6-bit divisor from 18 to 35. A value of 18 passes every cycle, and 35 gives a little over half the reference rate. Downstream logic uses the pulse as a clock enable in the reference domain. Division comes from a phase accumulator. The accumulator gains 18 on each enabled cycle. It gives back N, together with one pulse, each time the total reaches N.

Control sits in one byte-wide register lane on a small write/read bus. Bit 7 is a gate bit that stops the pulses. Bit 6 is a read-only flag, and bits 5:0 hold the programmed divisor. The bus accepts byte transfers only. Each write goes through one of four aliases: plain write, set bits, clear bits and invert bits. A new divisor does not reach the divider at once. It is taken over on the next output pulse, and the read-only flag inverts on that same cycle. Software reads the flag, writes the divisor, then polls until the flag has inverted. Gating the divider on or off never moves the flag.

Top module: `frac_clk_div`

## Requirements
- R1: After reset the lane reads 0x12: gate 0, flag 0, divisor 18. The accumulator starts at zero, and `bus_err` is low.
- R2: While ungated with an applied divisor N, any N consecutive cycles after the accumulator restart contain exactly 18 cycles with `clk_en_o` high.
- R3: Bit 7 (gate) set to 1 keeps `clk_en_o` low from the second cycle after the write onward. It also freezes the accumulator, so clearing the bit resumes the same phase.
- R4: Bit 6 (flag) inverts exactly once for each divisor that is applied, and never because the gate bit changes.
- R5: A divisor write is held pending until the next output pulse. On that pulse the divider takes the value and its accumulator restarts at zero. A pending value waits while the divider is gated.
- R6: A written divisor below 18 reads back and is applied as 18. One above 35 reads back and is applied as 35.
- R7: A transfer with `bus_size` other than 0 (byte) raises `bus_err` for the following cycle and changes no register bit.
- R8: `bus_addr` selects the write alias: 0 plain, 1 OR-in, 2 clear where written 1, 3 invert where written 1. Writes to bit 6 are ignored. An OR/clear/invert write whose bits 5:0 are all zero does not start a divisor update.
- R9: A plain write of the divisor already in use still inverts the flag once it is applied.
- R10: `bus_rdata` always shows {gate, flag, programmed divisor} in bits 7, 6 and 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (used only for size checking) |
| bus_addr | input | 2 | Alias select: 0 plain, 1 set, 2 clear, 3 invert |
| bus_size | input | 2 | Transfer size: 0 byte, 1 half-word, 2 word |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Lane contents {gate, flag, divisor} |
| bus_err | output | 1 | Registered error for a non-byte transfer |
| clk_en_o | output | 1 | Divided enable pulse |

## Verification
The hardest case to reach from the ports is a divisor that becomes pending while the divider is gated. Here no pulse boundary can occur, so the value must wait, and the flag must hold still both through the gating and through its removal. The stimulus sets the gate through the OR alias and then writes a new divisor with bit 7 still set. It idles well past several nominal periods and clears the gate through the clear alias. It then checks that the flag inverted once, only after the gate was removed. Rate windows of exactly N cycles after each apply check the 18/N ratio without depending on the accumulator phase.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
    typedef enum logic [1:0] {
        ALIAS_PLAIN = 2'd0,
        ALIAS_SET   = 2'd1,
        ALIAS_CLR   = 2'd2,
        ALIAS_TOG   = 2'd3
    } alias_e;

    typedef enum logic [1:0] {
        XFER_BYTE = 2'd0,
        XFER_HALF = 2'd1,
        XFER_WORD = 2'd2,
        XFER_RSVD = 2'd3
    } xfer_e;

    localparam int LANE_W   = 8;
    localparam int GATE_BIT = 7;
    localparam int FLAG_BIT = 6;
endpackage

// File: rtl/frac_reg_lane.sv
module frac_reg_lane
    import frac_div_pkg::*;
#(
    parameter int DIV_W     = 6,
    parameter int DIV_MIN   = 18,
    parameter int DIV_MAX   = 35,
    parameter int RESET_DIV = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [1:0]       addr_i,
    input  logic [1:0]       size_i,
    input  logic [LANE_W-1:0] wdata_i,
    input  logic             apply_i,
    output logic             gate_o,
    output logic [DIV_W-1:0] div_req_o,
    output logic             pend_o,
    output logic             err_o
);
    typedef struct packed {
        logic             gate;
        logic [DIV_W-1:0] div;
        logic             pend;
        logic             err;
    } lane_t;

    lane_t lane_d, lane_q;
    logic [LANE_W-1:0] cur_byte;
    logic [LANE_W-1:0] new_byte;
    logic              byte_ok;
    logic              touches_div;

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] v);
        if (int'(v) < DIV_MIN)      return DIV_W'(DIV_MIN);
        else if (int'(v) > DIV_MAX) return DIV_W'(DIV_MAX);
        else                        return v;
    endfunction

    always_comb begin
        cur_byte = '0;
        cur_byte[GATE_BIT] = lane_q.gate;
        cur_byte[DIV_W-1:0] = lane_q.div;

        unique case (alias_e'(addr_i))
            ALIAS_PLAIN: new_byte = wdata_i;
            ALIAS_SET:   new_byte = cur_byte | wdata_i;
            ALIAS_CLR:   new_byte = cur_byte & ~wdata_i;
            ALIAS_TOG:   new_byte = cur_byte ^ wdata_i;
            default:     new_byte = cur_byte;
        endcase

        byte_ok     = (xfer_e'(size_i) == XFER_BYTE);
        touches_div = (alias_e'(addr_i) == ALIAS_PLAIN) || (wdata_i[DIV_W-1:0] != '0);

        lane_d     = lane_q;
        lane_d.err = (wr_i || rd_i) && !byte_ok;
        if (apply_i) begin
            lane_d.pend = 1'b0;
        end
        if (wr_i && byte_ok) begin
            lane_d.gate = new_byte[GATE_BIT];
            lane_d.div  = clamp_div(new_byte[DIV_W-1:0]);
            if (touches_div) begin
                lane_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q      <= '0;
            lane_q.div  <= DIV_W'(RESET_DIV);
        end else begin
            lane_q <= lane_d;
        end
    end

    assign gate_o    = lane_q.gate;
    assign div_req_o = lane_q.div;
    assign pend_o    = lane_q.pend;
    assign err_o     = lane_q.err;

    AST_BAD_SIZE_KEEPS_LANE: assert property (@(posedge clk) disable iff (!rst_n) (wr_i && size_i != 2'd0) |=> ($stable(lane_q.gate) && $stable(lane_q.div))); // R7
    AST_REQ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (int'(lane_q.div) >= DIV_MIN && int'(lane_q.div) <= DIV_MAX)); // R6
    AST_PLAIN_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n) (wr_i && size_i == 2'd0 && addr_i == 2'd0) |=> lane_q.pend); // R5
endmodule

// File: rtl/frac_phase_accum.sv
module frac_phase_accum #(
    parameter int DIV_W     = 6,
    parameter int STEP      = 18,
    parameter int DIV_MIN   = 18,
    parameter int DIV_MAX   = 35,
    parameter int RESET_DIV = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_i,
    input  logic             pend_i,
    input  logic [DIV_W-1:0] div_req_i,
    output logic             apply_o,
    output logic             en_o,
    output logic             flag_o
);
    localparam int ACC_W = DIV_W + 1;
    localparam int SUM_W = DIV_W + 2;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [DIV_W-1:0] act;
        logic             flag;
        logic             en;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [SUM_W-1:0] sum;
    logic             hit;
    logic             apply;

    always_comb begin
        sum   = SUM_W'(acc_q.acc) + SUM_W'(STEP);
        hit   = !gate_i && (sum >= SUM_W'(acc_q.act));
        apply = hit && pend_i;

        acc_d    = acc_q;
        acc_d.en = hit;
        if (!gate_i) begin
            if (apply)    acc_d.acc = '0;
            else if (hit) acc_d.acc = ACC_W'(sum - SUM_W'(acc_q.act));
            else          acc_d.acc = ACC_W'(sum);
        end
        if (apply) begin
            acc_d.act  = div_req_i;
            acc_d.flag = !acc_q.flag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            acc_q.act <= DIV_W'(RESET_DIV);
        end else begin
            acc_q <= acc_d;
        end
    end

    assign apply_o = apply;
    assign en_o    = acc_q.en;
    assign flag_o  = acc_q.flag;

    AST_ACC_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n) (acc_q.acc < ACC_W'(acc_q.act))); // R2
    AST_GATE_SILENCES: assert property (@(posedge clk) disable iff (!rst_n) gate_i |=> !acc_q.en); // R3
    AST_GATE_FREEZES_PHASE: assert property (@(posedge clk) disable iff (!rst_n) gate_i |=> $stable(acc_q.acc)); // R3
    AST_FLAG_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(acc_q.flag) |-> acc_q.en); // R4
    AST_ACT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (int'(acc_q.act) >= DIV_MIN && int'(acc_q.act) <= DIV_MAX)); // R6
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import frac_div_pkg::*;
#(
    parameter int DIV_W     = 6,
    parameter int STEP      = 18,
    parameter int DIV_MIN   = 18,
    parameter int DIV_MAX   = 35,
    parameter int RESET_DIV = 18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [1:0] bus_size,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       bus_err,
    output logic       clk_en_o
);
    logic             gate;
    logic             pend;
    logic             apply;
    logic             flag;
    logic [DIV_W-1:0] div_req;

    frac_reg_lane #(
        .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX), .RESET_DIV(RESET_DIV)
    ) u_lane (
        .clk(clk), .rst_n(rst_n),
        .wr_i(bus_wr), .rd_i(bus_rd), .addr_i(bus_addr), .size_i(bus_size),
        .wdata_i(bus_wdata), .apply_i(apply),
        .gate_o(gate), .div_req_o(div_req), .pend_o(pend), .err_o(bus_err)
    );

    frac_phase_accum #(
        .DIV_W(DIV_W), .STEP(STEP), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX), .RESET_DIV(RESET_DIV)
    ) u_accum (
        .clk(clk), .rst_n(rst_n),
        .gate_i(gate), .pend_i(pend), .div_req_i(div_req),
        .apply_o(apply), .en_o(clk_en_o), .flag_o(flag)
    );

    always_comb begin
        bus_rdata = '0;
        bus_rdata[GATE_BIT] = gate;
        bus_rdata[FLAG_BIT] = flag;
        bus_rdata[DIV_W-1:0] = div_req;
    end
endmodule

// File: tb/frac_clk_div_tb.sv
module frac_clk_div_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [1:0] bus_size = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       bus_err;
    logic       clk_en_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    always #5 clk = ~clk;

    frac_clk_div u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .clk_en_o(clk_en_o)
    );

    // behavioural reference, integer state
    int m_gate = 0, m_div = 18, m_pend = 0, m_err = 0;
    int m_acc = 0, m_act = 18, m_flag = 0, m_en = 0;

    function automatic int clampv(int v);
        if (v < 18) return 18;
        if (v > 35) return 35;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_gate = 0; m_div = 18; m_pend = 0; m_err = 0;
            m_acc = 0; m_act = 18; m_flag = 0; m_en = 0;
        end else begin
            int gate_n, div_n, pend_n, acc_n, act_n, flag_n, en_n, oldb, newb;
            bit fire, take, okw;
            fire = (m_gate == 0) && (m_acc + 18 >= m_act);
            take = fire && (m_pend != 0);
            en_n = fire;
            acc_n = m_acc; act_n = m_act; flag_n = m_flag;
            if (m_gate == 0) acc_n = take ? 0 : (fire ? m_acc + 18 - m_act : m_acc + 18);
            if (take) begin act_n = m_div; flag_n = 1 - m_flag; end
            gate_n = m_gate; div_n = m_div; pend_n = take ? 0 : m_pend;
            okw = bus_wr && bus_size == 2'd0;
            if (okw) begin
                oldb = m_gate * 128 + m_div;
                case (bus_addr)
                    2'd0: newb = bus_wdata;
                    2'd1: newb = oldb | bus_wdata;
                    2'd2: newb = oldb & ~int'(bus_wdata);
                    default: newb = oldb ^ bus_wdata;
                endcase
                gate_n = (newb / 128) % 2;
                div_n = clampv(newb % 64);
                if (bus_addr == 2'd0 || (bus_wdata % 64) != 0) pend_n = 1;
            end
            m_err = ((bus_wr || bus_rd) && bus_size != 2'd0) ? 1 : 0;
            m_gate = gate_n; m_div = div_n; m_pend = pend_n;
            m_acc = acc_n; m_act = act_n; m_flag = flag_n; m_en = en_n;
        end
    end

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live && rst_n) begin
            check("R2 clk_en_o vs model", int'(clk_en_o), m_en);
            check("R10 bus_rdata vs model", int'(bus_rdata), m_gate * 128 + m_flag * 64 + m_div);
            check("R7 bus_err vs model", int'(bus_err), m_err);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d, logic [1:0] sz);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_wr = 1'b0; bus_size = 2'd0; bus_addr = 2'd0; bus_wdata = 8'd0;
    endtask

    task automatic count_pulses(int win, output int cnt);
        cnt = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            cnt += int'(clk_en_o);
        end
    endtask

    initial begin
        int c, f;
        idle(3);
        rst_n = 1'b1;
        live = 1'b1;
        @(negedge clk);
        check("R1 reset lane", int'(bus_rdata), 8'h12);
        check("R1 reset err", int'(bus_err), 0);

        count_pulses(18, c);
        check("R2 N=18 rate", c, 18);

        wr(2'd0, 8'd35, 2'd0);
        idle(4);
        check("R5 divisor applied readback", int'(bus_rdata[5:0]), 35);
        check("R4 flag inverted", int'(bus_rdata[6]), 1);
        count_pulses(35, c);
        check("R2 N=35 rate", c, 18);
        count_pulses(70, c);
        check("R2 N=35 double window", c, 36);

        wr(2'd1, 8'h80, 2'd0);
        idle(2);
        count_pulses(20, c);
        check("R3 gated no pulses", c, 0);
        check("R4 flag unchanged by gate on", int'(bus_rdata[6]), 1);
        wr(2'd2, 8'h80, 2'd0);
        idle(3);
        check("R4 flag unchanged by gate off", int'(bus_rdata[6]), 1);
        count_pulses(35, c);
        check("R3 resumed rate", c, 18);

        // pending divisor while gated
        wr(2'd1, 8'h80, 2'd0);
        wr(2'd0, 8'h80 | 8'd20, 2'd0);
        idle(60);
        check("R5 pending held while gated", int'(bus_rdata[6]), 1);
        check("R5 programmed value visible", int'(bus_rdata[5:0]), 20);
        wr(2'd2, 8'h80, 2'd0);
        idle(4);
        check("R5 applied after ungate", int'(bus_rdata[6]), 0);
        count_pulses(20, c);
        check("R2 N=20 rate", c, 18);

        wr(2'd0, 8'd5, 2'd0);
        check("R6 low clamp", int'(bus_rdata[5:0]), 18);
        wr(2'd0, 8'd63, 2'd0);
        check("R6 high clamp", int'(bus_rdata[5:0]), 35);
        idle(4);
        count_pulses(35, c);
        check("R6 clamped value applied", c, 18);

        wr(2'd3, 8'h01, 2'd0);
        check("R8 invert alias", int'(bus_rdata[5:0]), 34);
        wr(2'd1, 8'h01, 2'd0);
        check("R8 set alias", int'(bus_rdata[5:0]), 35);
        wr(2'd2, 8'h03, 2'd0);
        check("R8 clear alias", int'(bus_rdata[5:0]), 32);
        idle(5);

        f = int'(bus_rdata[6]);
        wr(2'd0, 8'h40 | 8'd30, 2'd0);
        check("R8 flag bit write ignored", int'(bus_rdata[6]), f);
        idle(5);
        check("R8 flag inverts on apply", int'(bus_rdata[6]), 1 - f);
        f = int'(bus_rdata[6]);
        wr(2'd1, 8'h80, 2'd0);
        wr(2'd2, 8'h80, 2'd0);
        idle(5);
        check("R8 gate-only alias writes no update", int'(bus_rdata[6]), f);

        f = int'(bus_rdata[6]);
        wr(2'd0, 8'd30, 2'd0);
        idle(5);
        check("R9 same value toggles flag", int'(bus_rdata[6]), 1 - f);

        c = int'(bus_rdata);
        wr(2'd0, 8'h99, 2'd2);
        check("R7 word write err", int'(bus_err), 1);
        check("R7 word write no change", int'(bus_rdata), c);
        wr(2'd3, 8'hFF, 2'd1);
        check("R7 half write err", int'(bus_err), 1);
        check("R7 half write no change", int'(bus_rdata), c);
        @(negedge clk); bus_rd = 1'b1; bus_size = 2'd1;
        @(negedge clk); bus_rd = 1'b0; bus_size = 2'd0;
        check("R7 half read err", int'(bus_err), 1);
        @(negedge clk); bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        check("R7 byte read no err", int'(bus_err), 0);
        idle(5);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule